// File: doc/BRIEF.md
# Thread-Group Stride Prefetch Engine

This block sits beside the load pipeline of one streaming multiprocessor and turns observed load issues into early line fetches for warps that have not yet run. Every observed load carries its instruction address, the thread-group (CTA) slot it belongs to, the warp number inside that group and the byte address it touched. One slot is named as the leading group. Loads from the leading group train a per-instruction stride, which is the address step between neighbouring warps. The stride is locked once the same step has been seen twice in a row.

A CTA's starting address cannot be derived from earlier CTAs, so the first load of a given instruction seen in any other slot is taken as that slot's base. That first warp is the group's own lead warp. If the instruction's stride is already locked and no burst is in progress, the engine walks every other warp of the group in ascending order, one per cycle. For each one it forms base plus (warp minus lead warp) times stride, rounds it down to a cache line, and offers it on a valid/ready request port through a small queue. The engine never stalls: requests that find the queue full are discarded. Retiring a slot forgets its bases so that a newly launched group can use the slot again.

Top module: `cta_stride_prefetch`

## Requirements
- R1: While reset is applied and in the first cycle after it, `pf_valid` is low, and no instruction entry holds a locked stride or a recorded base.
- R2: Only observations from the leading slot, with `obs_cta` equal to `lead_cta`, train the stride. A step counts only when `obs_warp` equals the previous observed warp of that instruction plus one (no wrap), and the step is the address difference. The stride locks when a step equals the step just before it. An unequal step replaces the held step, and a non-consecutive warp discards it.
- R3: Once an instruction's stride is locked, further leading-slot observations of that instruction do not change it.
- R4: The first observation of an instruction in a non-leading slot records that slot's base and lead warp. Later observations of the same instruction and slot are ignored until the slot is retired.
- R5: A burst starts in the cycle after the recording observation. In each following cycle it visits warps 0 to 2^WARP_W-1 in turn and skips the lead warp. The request address is (base + (w - lead) * stride) modulo 2^ADDR_W, with its low log2(LINE_BYTES) bits cleared. It carries the slot in `pf_cta` and w in `pf_warp`.
- R6: A base recorded while the instruction's stride is not yet locked produces no request.
- R7: A base recorded while a burst is still running (its final warp not yet visited) is kept but starts no burst.
- R8: The queue holds FIFO_DEPTH requests. A request generated while the queue is full, judged on its occupancy before that cycle's removal, is dropped, and the burst still moves on one warp per cycle.
- R9: While `pf_valid` is high and `pf_ready` is low, the request on the outputs stays unchanged. Requests leave in the order they were generated.
- R10: A cycle with `retire_valid` clears the recorded base of slot `retire_cta` for every instruction. This takes priority over a base recorded in the same cycle.
- R11: Observations from the leading slot never record a base or start a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lead_cta | input | CTA_W | Slot number of the leading thread group |
| obs_valid | input | 1 | A load issue is observed this cycle |
| obs_pc | input | PC_W | Instruction address bits selecting the table entry |
| obs_cta | input | CTA_W | Thread-group slot of the observed load |
| obs_warp | input | WARP_W | Warp number of the observed load inside its group |
| obs_addr | input | ADDR_W | Byte address of the observed load |
| retire_valid | input | 1 | A thread-group slot is released this cycle |
| retire_cta | input | CTA_W | Slot being released |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The consumer takes the offered request |
| pf_addr | output | ADDR_W | Line-aligned prefetch byte address |
| pf_cta | output | CTA_W | Slot the predicted warp belongs to |
| pf_warp | output | WARP_W | Predicted warp number |

## Verification
Stride training and burst generation run in parallel. The stimulus therefore feeds leading-slot loads of a second instruction, and a base claim for a third slot, while a burst for another slot is still emitting. The reference model must then show training that is unaffected, a kept but silent base, and an unbroken burst. A second overlap is queue insertion against queue removal and a full queue. Bursts are launched with `pf_ready` held low and then toggled every cycle, and every cycle the offered request and its presence are compared with the model's queue. That comparison shows which requests were dropped and that a stalled head did not move.

// File: rtl/pf_pkg.sv
package pf_pkg;

   // Per-instruction stride training progress.
   typedef enum logic [1:0] {
      TR_IDLE   = 2'd0,   // nothing seen yet
      TR_SEEN   = 2'd1,   // one warp address held, no step yet
      TR_ARMED  = 2'd2,   // one step held, waiting for confirmation
      TR_LOCKED = 2'd3    // stride confirmed and frozen
   } train_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pf_stride_table.sv
module pf_stride_table
   import pf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PC_W   = 3,
   parameter int CTA_W  = 2,
   parameter int WARP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTA_W-1:0]  lead_cta,
   input  logic              obs_valid,
   input  logic [PC_W-1:0]   obs_pc,
   input  logic [CTA_W-1:0]  obs_cta,
   input  logic [WARP_W-1:0] obs_warp,
   input  logic [ADDR_W-1:0] obs_addr,
   input  logic              retire_valid,
   input  logic [CTA_W-1:0]  retire_cta,
   input  logic              gen_busy,
   output logic              start,
   output logic [ADDR_W-1:0] start_stride
);

   localparam int NPC   = 1 << PC_W;
   localparam int NSLOT = 1 << CTA_W;

   train_e             st_arr   [NPC];
   logic [ADDR_W-1:0]  strd_arr [NPC];
   logic [NSLOT-1:0]   bv_arr   [NPC];

   logic from_lead;
   logic claim;

   assign from_lead = (obs_cta == lead_cta);
   assign claim     = obs_valid && !from_lead && !bv_arr[obs_pc][obs_cta];

   for (genvar p = 0; p < NPC; p++) begin : g_ent
      train_e            st;
      logic [ADDR_W-1:0] last_a;
      logic [ADDR_W-1:0] step;
      logic [ADDR_W-1:0] strd;
      logic [WARP_W-1:0] last_w;
      logic [NSLOT-1:0]  bv;
      logic              hit;
      logic              nxt_warp;
      logic [ADDR_W-1:0] delta;

      assign hit      = obs_valid && (obs_pc == PC_W'(p));
      assign delta    = obs_addr - last_a;
      assign nxt_warp = ({1'b0, obs_warp} == ({1'b0, last_w} + 1'b1));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st     <= TR_IDLE;
            last_a <= '0;
            last_w <= '0;
            step   <= '0;
            strd   <= '0;
            bv     <= '0;
         end else begin
            if (hit && from_lead && st != TR_LOCKED) begin
               last_a <= obs_addr;
               last_w <= obs_warp;
               unique case (st)
                  TR_IDLE: st <= TR_SEEN;
                  TR_SEEN: begin
                     if (nxt_warp) begin
                        step <= delta;
                        st   <= TR_ARMED;
                     end
                  end
                  TR_ARMED: begin
                     if (!nxt_warp) begin
                        st <= TR_SEEN;
                     end else if (delta == step) begin
                        strd <= delta;
                        st   <= TR_LOCKED;
                     end else begin
                        step <= delta;
                     end
                  end
                  default: ;
               endcase
            end
            if (hit && claim)
               bv[obs_cta] <= 1'b1;
            if (retire_valid)
               bv[retire_cta] <= 1'b0;
         end
      end

      assign st_arr[p]   = st;
      assign strd_arr[p] = strd;
      assign bv_arr[p]   = bv;
   end

   assign start        = claim && (st_arr[obs_pc] == TR_LOCKED) && !gen_busy;
   assign start_stride = strd_arr[obs_pc];

endmodule

// File: rtl/pf_burst_gen.sv
module pf_burst_gen #(
   parameter int ADDR_W     = 32,
   parameter int CTA_W      = 2,
   parameter int WARP_W     = 3,
   parameter int LINE_BYTES = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] start_base,
   input  logic [WARP_W-1:0] start_warp,
   input  logic [CTA_W-1:0]  start_cta,
   input  logic [ADDR_W-1:0] start_stride,
   output logic              busy,
   output logic              push,
   output logic [ADDR_W-1:0] push_addr,
   output logic [CTA_W-1:0]  push_cta,
   output logic [WARP_W-1:0] push_warp
);

   localparam int LINE_LSB = $clog2(LINE_BYTES);
   localparam int NW       = 1 << WARP_W;

   logic [ADDR_W-1:0] base_q;
   logic [ADDR_W-1:0] stride_q;
   logic [WARP_W-1:0] lead_q;
   logic [WARP_W-1:0] warp_q;
   logic [CTA_W-1:0]  cta_q;
   logic [ADDR_W-1:0] wdist;
   logic [ADDR_W-1:0] raw_addr;
   logic              last_warp;

   assign last_warp = (warp_q == WARP_W'(NW - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         base_q   <= '0;
         stride_q <= '0;
         lead_q   <= '0;
         warp_q   <= '0;
         cta_q    <= '0;
      end else if (start) begin
         busy     <= 1'b1;
         base_q   <= start_base;
         stride_q <= start_stride;
         lead_q   <= start_warp;
         warp_q   <= '0;
         cta_q    <= start_cta;
      end else if (busy) begin
         warp_q <= warp_q + 1'b1;
         if (last_warp)
            busy <= 1'b0;
      end
   end

   // Warp distance in two's complement, so products wrap modulo 2^ADDR_W.
   assign wdist    = ADDR_W'(warp_q) - ADDR_W'(lead_q);
   assign raw_addr = base_q + wdist * stride_q;

   if (LINE_LSB == 0) begin : g_byte_line
      assign push_addr = raw_addr;
   end else begin : g_wide_line
      assign push_addr = {raw_addr[ADDR_W-1:LINE_LSB], {LINE_LSB{1'b0}}};
   end

   assign push      = busy && (warp_q != lead_q);
   assign push_cta  = cta_q;
   assign push_warp = warp_q;

endmodule

// File: rtl/pf_req_fifo.sv
module pf_req_fifo #(
   parameter int DW    = 37,
   parameter int DEPTH = 4,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [DW-1:0]    din,
   input  logic             pop,
   output logic [DW-1:0]    dout,
   output logic [CNT_W-1:0] cnt
);

   localparam int PTR_W = $clog2(DEPTH);

   logic [DW-1:0]    mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             full;
   logic             empty;
   logic             wr_ok;
   logic             rd_ok;

   assign full  = (cnt == CNT_W'(DEPTH));
   assign empty = (cnt == '0);
   assign wr_ok = push && !full;
   assign rd_ok = pop && !empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
         if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
         if (wr_ok && !rd_ok)
            cnt <= cnt + 1'b1;
         else if (rd_ok && !wr_ok)
            cnt <= cnt - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok)
         mem[wr_ptr] <= din;
   end

   assign dout = mem[rd_ptr];

endmodule

// File: rtl/cta_stride_prefetch.sv
module cta_stride_prefetch
   import pf_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int PC_W       = 3,
   parameter int CTA_W      = 2,
   parameter int WARP_W     = 3,
   parameter int LINE_BYTES = 128,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CTA_W-1:0]  lead_cta,
   input  logic              obs_valid,
   input  logic [PC_W-1:0]   obs_pc,
   input  logic [CTA_W-1:0]  obs_cta,
   input  logic [WARP_W-1:0] obs_warp,
   input  logic [ADDR_W-1:0] obs_addr,
   input  logic              retire_valid,
   input  logic [CTA_W-1:0]  retire_cta,
   output logic              pf_valid,
   input  logic              pf_ready,
   output logic [ADDR_W-1:0] pf_addr,
   output logic [CTA_W-1:0]  pf_cta,
   output logic [WARP_W-1:0] pf_warp
);

   localparam int REQ_W = ADDR_W + CTA_W + WARP_W;
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   initial begin
      if (!is_pow2(LINE_BYTES) || $clog2(LINE_BYTES) >= ADDR_W)
         $fatal(1, "LINE_BYTES must be a power of two below the address range");
      if (!is_pow2(FIFO_DEPTH) || FIFO_DEPTH < 2)
         $fatal(1, "FIFO_DEPTH must be a power of two of at least 2");
      if (PC_W < 1 || CTA_W < 1 || WARP_W < 1)
         $fatal(1, "index widths must be at least 1");
   end

   logic              gen_start;
   logic              gen_busy;
   logic [ADDR_W-1:0] gen_stride;
   logic              fifo_push;
   logic [ADDR_W-1:0] push_addr;
   logic [CTA_W-1:0]  push_cta;
   logic [WARP_W-1:0] push_warp;
   logic [REQ_W-1:0]  head;
   logic [CNT_W-1:0]  fifo_cnt;

   pf_stride_table #(
      .ADDR_W (ADDR_W),
      .PC_W   (PC_W),
      .CTA_W  (CTA_W),
      .WARP_W (WARP_W)
   ) u_table (
      .clk          (clk),
      .rst_n        (rst_n),
      .lead_cta     (lead_cta),
      .obs_valid    (obs_valid),
      .obs_pc       (obs_pc),
      .obs_cta      (obs_cta),
      .obs_warp     (obs_warp),
      .obs_addr     (obs_addr),
      .retire_valid (retire_valid),
      .retire_cta   (retire_cta),
      .gen_busy     (gen_busy),
      .start        (gen_start),
      .start_stride (gen_stride)
   );

   pf_burst_gen #(
      .ADDR_W     (ADDR_W),
      .CTA_W      (CTA_W),
      .WARP_W     (WARP_W),
      .LINE_BYTES (LINE_BYTES)
   ) u_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (gen_start),
      .start_base   (obs_addr),
      .start_warp   (obs_warp),
      .start_cta    (obs_cta),
      .start_stride (gen_stride),
      .busy         (gen_busy),
      .push         (fifo_push),
      .push_addr    (push_addr),
      .push_cta     (push_cta),
      .push_warp    (push_warp)
   );

   pf_req_fifo #(
      .DW    (REQ_W),
      .DEPTH (FIFO_DEPTH),
      .CNT_W (CNT_W)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .din   ({push_addr, push_cta, push_warp}),
      .pop   (pf_valid && pf_ready),
      .dout  (head),
      .cnt   (fifo_cnt)
   );

   assign pf_valid = (fifo_cnt != '0);
   assign {pf_addr, pf_cta, pf_warp} = head;

endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
   parameter int ADDR_W     = 32,
   parameter int CTA_W      = 2,
   parameter int WARP_W     = 3,
   parameter int CNT_W      = 3,
   parameter int DEPTH      = 4,
   parameter int LINE_BYTES = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pf_valid,
   input logic              pf_ready,
   input logic [ADDR_W-1:0] pf_addr,
   input logic [CTA_W-1:0]  pf_cta,
   input logic [WARP_W-1:0] pf_warp,
   input logic [CNT_W-1:0]  fifo_cnt,
   input logic              gen_start,
   input logic              gen_busy
);

   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(LINE_BYTES - 1);

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rst_n) |-> !pf_valid); // R1

   AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr) && $stable(pf_cta) && $stable(pf_warp))); // R9

   AST_LINE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      pf_valid |-> ((pf_addr & LOW_MASK) == '0)); // R5

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CNT_W'(DEPTH)); // R8

   AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_cnt == CNT_W'(DEPTH) && !pf_ready) |=> (fifo_cnt == CNT_W'(DEPTH))); // R8

   AST_SINGLE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      gen_start |-> !gen_busy); // R7

endmodule

bind cta_stride_prefetch pf_checker #(
   .ADDR_W     (ADDR_W),
   .CTA_W      (CTA_W),
   .WARP_W     (WARP_W),
   .CNT_W      (CNT_W),
   .DEPTH      (FIFO_DEPTH),
   .LINE_BYTES (LINE_BYTES)
) u_pf_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .pf_valid  (pf_valid),
   .pf_ready  (pf_ready),
   .pf_addr   (pf_addr),
   .pf_cta    (pf_cta),
   .pf_warp   (pf_warp),
   .fifo_cnt  (fifo_cnt),
   .gen_start (gen_start),
   .gen_busy  (gen_busy)
);

// File: tb/test_cta_stride_prefetch.sv
`timescale 1ns/1ps
module test_cta_stride_prefetch;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 4;
   localparam int NW         = 8;
   localparam int NPC        = 8;
   localparam int NSLOT      = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  lead_cta = 2'd0;
   logic        obs_valid = 1'b0;
   logic [2:0]  obs_pc = '0;
   logic [1:0]  obs_cta = '0;
   logic [2:0]  obs_warp = '0;
   logic [31:0] obs_addr = '0;
   logic        retire_valid = 1'b0;
   logic [1:0]  retire_cta = '0;
   logic        pf_ready = 1'b1;
   logic        pf_valid;
   logic [31:0] pf_addr;
   logic [1:0]  pf_cta;
   logic [2:0]  pf_warp;

   always #(CLK_PERIOD/2) clk = ~clk;

   cta_stride_prefetch i_cta_stride_prefetch (
      .clk(clk), .rst_n(rst_n), .lead_cta(lead_cta),
      .obs_valid(obs_valid), .obs_pc(obs_pc), .obs_cta(obs_cta),
      .obs_warp(obs_warp), .obs_addr(obs_addr),
      .retire_valid(retire_valid), .retire_cta(retire_cta),
      .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
      .pf_cta(pf_cta), .pf_warp(pf_warp)
   );

   int    vectors = 0;
   int    miscompares = 0;
   bit    done = 0;
   string req = "R1";

   // Reference model state
   bit          m_seen [NPC];
   bit          m_hasd [NPC];
   bit          m_lock [NPC];
   logic [31:0] m_lasta [NPC];
   int          m_lastw [NPC];
   logic [31:0] m_step [NPC];
   logic [31:0] m_str [NPC];
   bit          m_base [NPC][NSLOT];
   logic [31:0] gq_a [$];
   int          gq_w [$];
   bit          gq_skip [$];
   logic [1:0]  g_cta;
   logic [31:0] fq_a [$];
   logic [1:0]  fq_c [$];
   logic [2:0]  fq_w [$];

   always @(posedge clk) begin
      int          pre;
      bit          busy_pre;
      bit          take;
      logic [31:0] a;
      logic [31:0] d;
      logic [31:0] off;
      int          w;
      bit          s;
      int          pc;
      if (!rst_n) begin
         for (int p = 0; p < NPC; p++) begin
            m_seen[p] = 0; m_hasd[p] = 0; m_lock[p] = 0;
            for (int c = 0; c < NSLOT; c++) m_base[p][c] = 0;
         end
         gq_a.delete(); gq_w.delete(); gq_skip.delete();
         fq_a.delete(); fq_c.delete(); fq_w.delete();
      end else begin
         pre      = fq_a.size();
         busy_pre = (gq_a.size() != 0);
         take     = pf_ready && (pre > 0);
         if (busy_pre) begin
            a = gq_a.pop_front(); w = gq_w.pop_front(); s = gq_skip.pop_front();
            if (!s && pre < DEPTH) begin   // R8 drop when full
               fq_a.push_back(a); fq_c.push_back(g_cta); fq_w.push_back(3'(w));
            end
         end
         if (take) begin
            void'(fq_a.pop_front()); void'(fq_c.pop_front()); void'(fq_w.pop_front());
         end
         if (obs_valid) begin
            pc = int'(obs_pc);
            if (obs_cta == lead_cta) begin
               if (!m_lock[pc]) begin
                  if (m_seen[pc] && int'(obs_warp) == m_lastw[pc] + 1) begin
                     d = obs_addr - m_lasta[pc];
                     if (m_hasd[pc] && d == m_step[pc]) begin
                        m_lock[pc] = 1; m_str[pc] = d;
                     end else begin
                        m_hasd[pc] = 1; m_step[pc] = d;
                     end
                  end else begin
                     m_hasd[pc] = 0;
                  end
                  m_seen[pc] = 1; m_lasta[pc] = obs_addr; m_lastw[pc] = int'(obs_warp);
               end
            end else if (!m_base[pc][obs_cta]) begin
               m_base[pc][obs_cta] = 1;
               if (m_lock[pc] && !busy_pre) begin
                  g_cta = obs_cta;
                  for (int k = 0; k < NW; k++) begin
                     off = 32'(k - int'(obs_warp));
                     a = obs_addr + off * m_str[pc];
                     a[6:0] = 7'd0;
                     gq_a.push_back(a); gq_w.push_back(k); gq_skip.push_back(k == int'(obs_warp));
                  end
               end
            end
         end
         if (retire_valid)
            for (int p = 0; p < NPC; p++) m_base[p][retire_cta] = 0;
      end
   end

   always @(negedge clk) begin
      bit exp_v;
      bit bad;
      if (!done) begin
         vectors++;
         exp_v = (fq_a.size() != 0);
         bad = (pf_valid !== exp_v);
         if (exp_v && !bad)
            bad = (pf_addr !== fq_a[0]) || (pf_cta !== fq_c[0]) || (pf_warp !== fq_w[0]);
         if (bad) begin
            miscompares++;
            if (exp_v)
               $display("FAIL %s t=%0t got v=%0b a=%h c=%0d w=%0d exp v=1 a=%h c=%0d w=%0d",
                        req, $time, pf_valid, pf_addr, pf_cta, pf_warp, fq_a[0], fq_c[0], fq_w[0]);
            else
               $display("FAIL %s t=%0t got v=%0b a=%h exp v=0", req, $time, pf_valid, pf_addr);
         end
      end
   end

   task automatic obs(input int pc, input int cta, input int w, input logic [31:0] a);
      @(negedge clk); #1;
      obs_valid = 1'b1; obs_pc = 3'(pc); obs_cta = 2'(cta); obs_warp = 3'(w); obs_addr = a;
      retire_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk); #1;
         obs_valid = 1'b0; retire_valid = 1'b0;
      end
   endtask

   task automatic retire(input int cta);
      @(negedge clk); #1;
      obs_valid = 1'b0; retire_valid = 1'b1; retire_cta = 2'(cta);
   endtask

   initial begin
      req = "R1"; // reset: nothing offered
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      idle(2);

      req = "R6"; // base claimed before stride locks gives no request
      obs(1, 0, 0, 32'h1000);
      obs(1, 0, 1, 32'h1100);
      obs(1, 1, 2, 32'h5000);
      req = "R2"; // second equal step locks stride 0x100
      obs(1, 0, 2, 32'h1200);
      req = "R4"; // slot 1 already claimed for pc 1: ignored
      obs(1, 1, 5, 32'h6000);
      idle(10);

      req = "R5"; // burst for slot 2 around lead warp 3
      obs(1, 2, 3, 32'h8040);
      req = "R2"; // pc 2 training overlaps burst: steps 0x80, 0x100, 0x100
      obs(2, 0, 0, 32'h0);
      obs(2, 0, 1, 32'h80);
      obs(2, 0, 2, 32'h180);
      req = "R7"; // slot 3 claim while busy: recorded, silent
      obs(1, 3, 0, 32'h9000);
      obs(2, 0, 3, 32'h280);
      idle(12);
      req = "R7"; // slot 3 pc 1 already claimed: no burst now either
      obs(1, 3, 1, 32'h9100);
      idle(10);

      req = "R8"; // consumer stalled: only DEPTH requests survive
      pf_ready = 1'b0;
      obs(2, 2, 1, 32'h20000);
      idle(12);
      req = "R9";
      idle(4);
      pf_ready = 1'b1;
      idle(8);

      req = "R10"; // retire clears slot, new claim bursts again
      retire(2);
      obs(1, 2, 0, 32'hA000);
      idle(12);
      retire(3);
      obs(2, 3, 7, 32'hC000);
      idle(12);

      req = "R3"; // locked stride unaffected by new lead steps
      obs(1, 0, 4, 32'h0);
      obs(1, 0, 5, 32'h40);
      obs(1, 0, 6, 32'h80);
      req = "R11"; // lead-slot loads of a locked pc: no burst
      idle(10);
      req = "R3";
      retire(1);
      obs(1, 1, 2, 32'h3000);
      idle(12);

      req = "R5"; // negative stride with toggled ready
      obs(3, 0, 0, 32'h4000);
      obs(3, 0, 1, 32'h3F00);
      obs(3, 0, 2, 32'h3E00);
      obs(3, 1, 4, 32'h10000);
      for (int i = 0; i < 14; i++) begin
         idle(1);
         pf_ready = ~pf_ready;
      end
      pf_ready = 1'b1;
      req = "R10"; // retire and claim in same cycle for slot 1 on pc 4: retire wins
      @(negedge clk); #1;
      obs_valid = 1'b1; obs_pc = 3'd4; obs_cta = 2'd1; obs_warp = 3'd0; obs_addr = 32'h500;
      retire_valid = 1'b1; retire_cta = 2'd1;
      idle(10);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         miscompares++;
         $display("FAIL watchdog %s: run did not finish, exp completion", req);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule